// File: doc/BRIEF.md
# SPI Master Register and FIFO Status Unit

This block is the bus-facing half of a SPI master controller. A host reads and writes 32-bit words at byte offsets. The block holds the controller's control word and five plain configuration words. It also holds a transmit FIFO and a receive FIFO of 32-bit words. A status word reports the FIFO levels live and keeps two sticky event bits. A level interrupt fires when any enabled status bit is set. The block also drives one active-low chip-select per channel.

The block does no serial shifting. It presents the head of the transmit FIFO to a separate burst engine and gives it a one-cycle start request. The engine pops transmit words, pushes received words and reports when a burst has finished.

When the control word is written with its enable bit clear, the block performs a soft reset. Every register except the control word returns to its reset state, and the block then ignores writes to all other registers until it is enabled again.

Top module: `spictl_regs`

## Requirements
- R1: Register index is the byte offset divided by 4. The map is: 0 RX data, 1 TX data, 2 control, 3 config, 4 interrupt enable, 5 DMA, 6 status, 7 period, 8 test, 9 message. Config, interrupt enable, DMA, period and test read back what was written. A read at index 10 or above returns 0, and a write there changes nothing.
- R2: While control bit 0 (enable) is clear, writes to every register other than control are ignored. Also while enable is clear, irq stays low.
- R3: A control write with bit 0 clear is a soft reset. The control register takes the written value. Both FIFOs empty. The five plain registers become 0 and status reads 0x3. All chip-selects go high, and irq goes low.
- R4: After hard reset: control reads 0, status reads 0x3, csN is all ones, irq is 0, xferReq is 0 and engTxAvail is 0.
- R5: Status bits are live. Bit 0 means TX empty, bit 2 TX full (64 words), bit 3 RX not empty and bit 5 RX full (64 words). Bit 1 is 1 after either reset. Bit 4 and bits 31:8 read 0.
- R6: Bit 6 (RX overflow) and bit 7 (transfer done) are sticky. Writing 1 to one of them clears it. Writes to any other status bit have no effect.
- R7: irq is high exactly when status AND interrupt-enable is nonzero.
- R8: With enable set, reading RX data pops the oldest RX word. An empty RX FIFO reads 0xDEADBEEF. Reads of TX data and message return 0.
- R9: A TX data write when the TX FIFO holds 64 words is dropped. Writes to RX data and message registers change nothing.
- R10: A control write with enable set, where mode bit [4+sel] is set (mode field bits 7:4, sel field bits 19:18), drives csN[sel] low and the other lines high. A control write to a channel whose mode bit is clear leaves csN unchanged.
- R11: engTxAvail and engTxData show the TX FIFO head, and engTxPop removes it. engRxPush stores engRxData in the RX FIFO. A push into a full RX FIFO is dropped and sets status bit 6. engDone sets status bit 7.
- R12: xferReq pulses for one cycle in the following cases, each only when the written control value has enable set and the selected channel is master: a control write that raises bit 2 (exchange) while bit 3 (immediate) is clear; a control write that raises bit 3 while the TX FIFO is not empty. It also pulses after an accepted TX write while the stored control word has enable, a master channel and bit 3 set.
- R13: Read data appears on busRdata in the cycle after the read strobe. The effects of a write are visible in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |
| csN | output | 4 | Active-low chip-selects |
| xferReq | output | 1 | Start pulse to the burst engine |
| engTxData | output | 32 | TX FIFO head |
| engTxAvail | output | 1 | TX FIFO not empty |
| engTxPop | input | 1 | Engine consumes the TX head |
| engRxData | input | 32 | Received word |
| engRxPush | input | 1 | Store engRxData |
| engDone | input | 1 | Burst finished |

## Verification
Every result is due one clock after the strobe that causes it. Read data, FIFO levels, status bits, chip-selects and xferReq are all registered at the edge that samples the strobe. irq follows from those registers with no further delay. The bench drives each strobe for exactly one cycle from a falling edge and samples at the following falling edge, which is the first point where the result is due. For xferReq, the bench also samples one cycle later to confirm that the pulse has ended. A bench model of both FIFOs, the sticky bits and the enable mask supplies every expected value.

// File: rtl/spictl_pkg.sv
package spictl_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_CS   = 4;
  localparam int SEL_W    = $clog2(NUM_CS);
  localparam int NUM_GEN  = 5;
  localparam int NUM_REGS = 10;

  localparam int CTRL_EN       = 0;
  localparam int CTRL_XCH      = 2;
  localparam int CTRL_IMM      = 3;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CTRL_SEL_LSB  = 18;

  localparam int ST_TXE  = 0;
  localparam int ST_TDR  = 1;
  localparam int ST_TXF  = 2;
  localparam int ST_RXR  = 3;
  localparam int ST_RXF  = 5;
  localparam int ST_OVF  = 6;
  localparam int ST_DONE = 7;

  localparam logic [DATA_W-1:0] RX_EMPTY_WORD = 32'hDEAD_BEEF;

  typedef enum logic [3:0] {
    SEL_RX = 4'd0, SEL_TX = 4'd1, SEL_CTRL = 4'd2, SEL_CFG = 4'd3,
    SEL_INTEN = 4'd4, SEL_DMA = 4'd5, SEL_STAT = 4'd6, SEL_PERIOD = 4'd7,
    SEL_TEST = 4'd8, SEL_MSG = 4'd9, SEL_NONE = 4'd15
  } regSel_e;

  typedef struct packed {
    logic en;
    logic xch;
    logic imm;
    logic master;
  } ctrlFlags_t;

  typedef struct packed {
    logic               wrCtrl;
    logic [NUM_GEN-1:0] wrGen;
    logic               wrStat;
    logic               txPush;
    logic               rxPop;
    logic               softRst;
    logic               csDrive;
    logic               startReq;
    logic               rdEn;
    regSel_e            rdSel;
  } strobes_t;

  // plain register k sits at this selector (status interrupts the run)
  function automatic regSel_e genSel(input int k);
    return (k < 3) ? regSel_e'(4'(3 + k)) : regSel_e'(4'(4 + k));
  endfunction

  function automatic ctrlFlags_t decodeCtrl(input logic [DATA_W-1:0] c);
    ctrlFlags_t f;
    logic [NUM_CS-1:0] mode;
    logic [SEL_W-1:0]  sel;
    mode     = c[CTRL_MODE_LSB +: NUM_CS];
    sel      = c[CTRL_SEL_LSB +: SEL_W];
    f.en     = c[CTRL_EN];
    f.xch    = c[CTRL_XCH];
    f.imm    = c[CTRL_IMM];
    f.master = mode[sel];
    return f;
  endfunction
endpackage

// File: rtl/spictl_fifo.sv
module spictl_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             wrOk, rdOk;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign wrOk  = push && !full;
  assign rdOk  = pop && !empty;
  assign dout  = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrOk) wrPtr <= nextPtr(wrPtr);
      if (rdOk) rdPtr <= nextPtr(rdPtr);
      if (wrOk && !rdOk)      count <= count + CW'(1);
      else if (rdOk && !wrOk) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/spictl_ctrl.sv
module spictl_ctrl
  import spictl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              [ADDR_W-3:0] busIdx,
  input  logic                           busWr,
  input  logic                           busRd,
  input  ctrlFlags_t                     wdFlags,
  input  ctrlFlags_t                     curFlags,
  input  logic                           txFull,
  input  logic                           txEmpty,
  input  logic                           rxEmpty,
  output strobes_t                       stb
);
  localparam int IDX_W = ADDR_W - 2;

  regSel_e            sel;
  logic [NUM_GEN-1:0] wrGenV;
  logic               en, wrCtrlHit, txPushV, ctrlStart, txStart;

  assign en  = curFlags.en;
  assign sel = (busIdx < IDX_W'(NUM_REGS)) ? regSel_e'(busIdx[3:0]) : SEL_NONE;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen_wr
    assign wrGenV[g] = busWr && en && (sel == genSel(g));
  end

  assign wrCtrlHit = busWr && (sel == SEL_CTRL);
  assign txPushV   = busWr && en && (sel == SEL_TX) && !txFull;

  // start conditions of a control write judged on the written value
  assign ctrlStart = wrCtrlHit && wdFlags.en && wdFlags.master &&
                     ((wdFlags.xch && !curFlags.xch && !wdFlags.imm) ||
                      (wdFlags.imm && !curFlags.imm && !txEmpty));
  assign txStart   = txPushV && curFlags.master && curFlags.imm;

  always_comb begin
    stb          = '0;
    stb.wrCtrl   = wrCtrlHit;
    stb.wrGen    = wrGenV;
    stb.wrStat   = busWr && en && (sel == SEL_STAT);
    stb.txPush   = txPushV;
    stb.rxPop    = busRd && en && (sel == SEL_RX) && !rxEmpty;
    stb.softRst  = wrCtrlHit && !wdFlags.en;
    stb.csDrive  = wrCtrlHit && wdFlags.en && wdFlags.master;
    stb.startReq = ctrlStart || txStart;
    stb.rdEn     = busRd;
    stb.rdSel    = sel;
  end
endmodule

// File: rtl/spictl_dpath.sv
module spictl_dpath
  import spictl_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                engTxPop,
  input  logic                engRxPush,
  input  logic [DATA_W-1:0]   engRxData,
  input  logic                engDone,
  output logic [DATA_W-1:0]   busRdata,
  output logic [NUM_CS-1:0]   csN,
  output logic                irq,
  output logic                xferReq,
  output logic [DATA_W-1:0]   engTxData,
  output logic                engTxAvail,
  output ctrlFlags_t          curFlags,
  output logic                txFull,
  output logic                txEmpty,
  output logic                rxEmpty
);
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] genReg [NUM_GEN];
  logic [DATA_W-1:0] rxHead, statusVal, rdVal;
  logic              rxFull, stTdr, stOvf, stDone, rxDrop;
  logic [SEL_W-1:0]  wSel;

  assign curFlags = decodeCtrl(ctrlReg);
  assign wSel     = busWdata[CTRL_SEL_LSB +: SEL_W];
  assign rxDrop   = engRxPush && rxFull;

  spictl_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(stb.softRst), .push(stb.txPush),
    .pop(engTxPop), .din(busWdata), .dout(engTxData),
    .empty(txEmpty), .full(txFull));

  spictl_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(stb.softRst), .push(engRxPush),
    .pop(stb.rxPop), .din(engRxData), .dout(rxHead),
    .empty(rxEmpty), .full(rxFull));

  assign engTxAvail = !txEmpty;

  always_comb begin
    statusVal          = '0;
    statusVal[ST_TXE]  = txEmpty;
    statusVal[ST_TDR]  = stTdr;
    statusVal[ST_TXF]  = txFull;
    statusVal[ST_RXR]  = !rxEmpty;
    statusVal[ST_RXF]  = rxFull;
    statusVal[ST_OVF]  = stOvf;
    statusVal[ST_DONE] = stDone;
  end

  assign irq = |(statusVal & genReg[1]);

  always_comb begin
    unique case (stb.rdSel)
      SEL_RX:     rdVal = !curFlags.en ? '0 : (rxEmpty ? RX_EMPTY_WORD : rxHead);
      SEL_CTRL:   rdVal = ctrlReg;
      SEL_STAT:   rdVal = statusVal;
      SEL_CFG:    rdVal = genReg[0];
      SEL_INTEN:  rdVal = genReg[1];
      SEL_DMA:    rdVal = genReg[2];
      SEL_PERIOD: rdVal = genReg[3];
      SEL_TEST:   rdVal = genReg[4];
      default:    rdVal = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               genReg[g] <= '0;
      else if (stb.softRst)    genReg[g] <= '0;
      else if (stb.wrGen[g])   genReg[g] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      stTdr    <= 1'b1;
      stOvf    <= 1'b0;
      stDone   <= 1'b0;
      csN      <= '1;
      xferReq  <= 1'b0;
      busRdata <= '0;
    end else begin
      xferReq <= stb.startReq;
      if (stb.rdEn) busRdata <= rdVal;
      if (stb.wrCtrl) ctrlReg <= busWdata;
      if (stb.softRst) begin
        stTdr  <= 1'b1;
        stOvf  <= 1'b0;
        stDone <= 1'b0;
        csN    <= '1;
      end else begin
        if (stb.csDrive) csN <= ~(NUM_CS'(1) << wSel);
        if (rxDrop)                                   stOvf <= 1'b1;
        else if (stb.wrStat && busWdata[ST_OVF])      stOvf <= 1'b0;
        if (engDone)                                  stDone <= 1'b1;
        else if (stb.wrStat && busWdata[ST_DONE])     stDone <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spictl_regs.sv
module spictl_regs
  import spictl_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int FIFO_DEPTH = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                irq,
  output logic [NUM_CS-1:0]   csN,
  output logic                xferReq,
  output logic [DATA_W-1:0]   engTxData,
  output logic                engTxAvail,
  input  logic                engTxPop,
  input  logic [DATA_W-1:0]   engRxData,
  input  logic                engRxPush,
  input  logic                engDone
);
  strobes_t   stb;
  ctrlFlags_t curFlags, wdFlags;
  logic       txFull, txEmpty, rxEmpty, ctrlEn;

  assign wdFlags = decodeCtrl(busWdata);
  assign ctrlEn  = curFlags.en;

  spictl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busIdx(busAddr[ADDR_W-1:2]), .busWr(busWr), .busRd(busRd),
    .wdFlags(wdFlags), .curFlags(curFlags), .txFull(txFull),
    .txEmpty(txEmpty), .rxEmpty(rxEmpty), .stb(stb));

  spictl_dpath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .engTxPop(engTxPop), .engRxPush(engRxPush), .engRxData(engRxData),
    .engDone(engDone), .busRdata(busRdata), .csN(csN), .irq(irq),
    .xferReq(xferReq), .engTxData(engTxData), .engTxAvail(engTxAvail),
    .curFlags(curFlags), .txFull(txFull), .txEmpty(txEmpty),
    .rxEmpty(rxEmpty));
endmodule

// File: rtl/spictl_regs_chk.sv
module spictl_regs_chk
  import spictl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWr,
  input logic                busRd,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W-1:0]   busRdata,
  input logic [NUM_CS-1:0]   csN,
  input logic                irq,
  input logic                xferReq,
  input logic                ctrlEn
);
  logic [ADDR_W-3:0] idx;
  logic [SEL_W-1:0]  wSel;
  logic [NUM_CS-1:0] wMode;
  logic              isCtrl;

  assign idx    = busAddr[ADDR_W-1:2];
  assign wSel   = busWdata[CTRL_SEL_LSB +: SEL_W];
  assign wMode  = busWdata[CTRL_MODE_LSB +: NUM_CS];
  assign isCtrl = (idx == (ADDR_W-2)'(SEL_CTRL));

  p_rd_oob_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && idx >= (ADDR_W-2)'(NUM_REGS)) |=> (busRdata == '0));

  p_dis_irq_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |-> !irq);

  p_soft_rst_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && isCtrl && !busWdata[CTRL_EN]) |=> (csN == '1 && !irq && !ctrlEn));

  p_tx_rd_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && idx == (ADDR_W-2)'(SEL_TX)) |=> (busRdata == '0));

  p_cs_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && isCtrl && busWdata[CTRL_EN] && wMode[wSel])
      |=> (csN == ~(NUM_CS'(1) << $past(wSel))));

  p_req_after_wr_r12: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |-> $past(busWr));
endmodule

bind spictl_regs spictl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .busRdata(busRdata), .csN(csN), .irq(irq),
  .xferReq(xferReq), .ctrlEn(ctrlEn));

// File: tb/spictl_regs_bench.sv
`timescale 1ns/1ps
module spictl_regs_bench;
  localparam int ADDR_W = 12;
  localparam int DEPTH  = 64;
  localparam int I_RX = 0, I_TX = 1, I_CTRL = 2, I_CFG = 3, I_INTEN = 4,
                 I_STAT = 6, I_MSG = 9;
  localparam logic [31:0] C_ON   = 32'h0004_0021; // enable, mode 0010, sel 1
  localparam logic [31:0] C_XCH  = 32'h0004_0025;
  localparam logic [31:0] C_IMM  = 32'h0004_0029;
  localparam logic [31:0] C_SEL2 = 32'h0008_0021; // sel 2, not master

  logic clk = 0, rstN = 0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWr = 0, busRd = 0, engTxPop = 0, engRxPush = 0, engDone = 0;
  logic [31:0] busWdata = '0, engRxData = '0;
  logic [31:0] busRdata, engTxData;
  logic irq, xferReq, engTxAvail;
  logic [3:0] csN;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] txQ[$], rxQ[$];
  logic ovfM = 0, doneM = 0;
  logic [31:0] intenM = '0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  spictl_regs #(.ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH)) u_spictl_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .csN(csN),
    .xferReq(xferReq), .engTxData(engTxData), .engTxAvail(engTxAvail),
    .engTxPop(engTxPop), .engRxData(engRxData), .engRxPush(engRxPush),
    .engDone(engDone));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    s[0] = (txQ.size() == 0);
    s[1] = 1'b1;
    s[2] = (txQ.size() == DEPTH);
    s[3] = (rxQ.size() != 0);
    s[5] = (rxQ.size() == DEPTH);
    s[6] = ovfM;
    s[7] = doneM;
    return s;
  endfunction

  function automatic logic expIrq();
    return |(expStatus() & intenM);
  endfunction

  task automatic wrReg(input int idx, input logic [31:0] v);
    @(negedge clk);
    busAddr = ADDR_W'(idx * 4); busWdata = v; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rdReg(input int idx, output logic [31:0] v);
    @(negedge clk);
    busAddr = ADDR_W'(idx * 4); busRd = 1;
    @(negedge clk);
    busRd = 0;
    v = busRdata;
  endtask

  task automatic txWrite(input logic [31:0] v);
    wrReg(I_TX, v);
    if (txQ.size() < DEPTH) txQ.push_back(v);
  endtask

  task automatic engPop();
    @(negedge clk);
    chk(engTxAvail == (txQ.size() != 0), "R11 tx avail", 32'(engTxAvail), 32'(txQ.size() != 0));
    if (txQ.size() != 0) begin
      chk(engTxData == txQ[0], "R11 tx head", engTxData, txQ[0]);
      engTxPop = 1;
      @(negedge clk);
      engTxPop = 0;
      void'(txQ.pop_front());
    end
  endtask

  task automatic engPush(input logic [31:0] v);
    @(negedge clk);
    engRxData = v; engRxPush = 1;
    @(negedge clk);
    engRxPush = 0;
    if (rxQ.size() == DEPTH) ovfM = 1; else rxQ.push_back(v);
  endtask

  task automatic engFinish();
    @(negedge clk); engDone = 1;
    @(negedge clk); engDone = 0;
    doneM = 1;
  endtask

  task automatic rxRead(input string req);
    logic [31:0] e;
    e = (rxQ.size() == 0) ? 32'hDEAD_BEEF : rxQ.pop_front();
    rdReg(I_RX, rd);
    chk(rd == e, req, rd, e);
  endtask

  task automatic statCheck(input string req);
    rdReg(I_STAT, rd);
    chk(rd == expStatus(), req, rd, expStatus());
  endtask

  task automatic statW1c(input logic [31:0] v);
    wrReg(I_STAT, v);
    if (v[6]) ovfM = 0;
    if (v[7]) doneM = 0;
  endtask

  task automatic irqCheck(input string req);
    chk(irq == expIrq(), req, 32'(irq), 32'(expIrq()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R4 hard reset state
    chk(csN == 4'hF, "R4 csN", 32'(csN), 32'hF);
    chk(!irq && !xferReq && !engTxAvail, "R4 outputs", {29'b0, irq, xferReq, engTxAvail}, 0);
    rdReg(I_CTRL, rd); chk(rd == 0, "R4 ctrl", rd, 0);
    rdReg(I_STAT, rd); chk(rd == 32'h3, "R4 status", rd, 32'h3);

    // R2 writes ignored while disabled
    wrReg(I_INTEN, 32'hFF); wrReg(I_CFG, 32'h1234); wrReg(I_TX, 32'h5);
    rdReg(I_INTEN, rd); chk(rd == 0, "R2 inten", rd, 0);
    rdReg(I_CFG, rd); chk(rd == 0, "R2 cfg", rd, 0);
    chk(!engTxAvail && !irq, "R2 tx/irq", {30'b0, engTxAvail, irq}, 0);

    // R10 chip select, R1 map and out of range
    wrReg(I_CTRL, C_ON);
    chk(csN == 4'b1101, "R10 cs sel1", 32'(csN), 32'hD);
    wrReg(I_CFG, 32'hA5A5_1234);
    rdReg(I_CFG, rd); chk(rd == 32'hA5A5_1234, "R1 cfg readback", rd, 32'hA5A5_1234);
    wrReg(12, 32'hFFFF);
    rdReg(12, rd); chk(rd == 0, "R1 oob read", rd, 0);
    rdReg(255, rd); chk(rd == 0, "R1 far oob read", rd, 0);
    rdReg(I_CFG, rd); chk(rd == 32'hA5A5_1234, "R1 oob write no effect", rd, 32'hA5A5_1234);
    wrReg(I_CTRL, C_SEL2);
    chk(csN == 4'b1101, "R10 cs unchanged non-master", 32'(csN), 32'hD);
    wrReg(I_CTRL, C_ON);

    // R8 reads, R9 ignored writes
    rxRead("R8 empty rx");
    rdReg(I_TX, rd); chk(rd == 0, "R8 tx read", rd, 0);
    rdReg(I_MSG, rd); chk(rd == 0, "R8 msg read", rd, 0);
    wrReg(I_MSG, 32'h99); wrReg(I_RX, 32'h77);
    statCheck("R9 rx/msg writes ignored");
    rdReg(I_MSG, rd); chk(rd == 0, "R9 msg stays 0", rd, 0);

    // R12 start request and R13 timing
    wrReg(I_CTRL, C_XCH);
    chk(xferReq == 1, "R12 xch pulse", 32'(xferReq), 1);
    @(negedge clk); chk(xferReq == 0, "R12 pulse one cycle", 32'(xferReq), 0);
    wrReg(I_CTRL, C_ON);
    chk(xferReq == 0, "R12 no pulse on xch fall", 32'(xferReq), 0);
    wrReg(I_CTRL, C_IMM);
    chk(xferReq == 0, "R12 imm with empty tx", 32'(xferReq), 0);
    txWrite(32'h77);
    chk(xferReq == 1, "R12 imm tx write", 32'(xferReq), 1);
    engPop();
    wrReg(I_CTRL, C_ON);

    // R5 TX fill, R9 drop, R11 drain
    for (int i = 0; i < DEPTH; i++) txWrite(32'hC000_0000 + 32'(i));
    statCheck("R5 tx full");
    txWrite(32'hDEAD_0000);
    for (int i = 0; i <= DEPTH; i++) engPop();
    statCheck("R9 dropped word absent");

    // R7 irq, R5 rx status, R11 overflow, R6 W1C
    wrReg(I_INTEN, 32'h08); intenM = 32'h08;
    irqCheck("R7 irq low");
    engPush(32'h11);
    irqCheck("R7 irq on rx ready");
    rxRead("R8 rx pop");
    irqCheck("R7 irq clears");
    for (int i = 0; i < DEPTH; i++) engPush(32'h5000_0000 + 32'(i));
    statCheck("R5 rx full");
    engPush(32'hBAD0_BAD0);
    statCheck("R11 overflow sticky");
    statW1c(32'hFFFF_FF3F);
    statCheck("R6 only w1c bits writable");
    statW1c(32'hFF);
    statCheck("R6 ovf cleared");
    engFinish();
    statCheck("R11 done set");
    statW1c(32'h40);
    statCheck("R6 done kept");
    statW1c(32'h80);
    statCheck("R6 done cleared");
    for (int i = 0; i <= DEPTH; i++) rxRead("R8 rx order");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      case ($urandom_range(0, 7))
        0: txWrite($urandom);
        1: engPop();
        2: engPush($urandom);
        3: rxRead("R8 random rx");
        4: statCheck("R5 random status");
        5: statW1c($urandom);
        6: begin intenM = $urandom & 32'hFF; wrReg(I_INTEN, intenM); end
        default: engFinish();
      endcase
      irqCheck("R7 random irq");
    end

    // R3 soft reset
    txWrite(32'h1); engPush(32'h2);
    wrReg(I_INTEN, 32'hFF); intenM = 32'hFF;
    wrReg(I_CTRL, 32'h0004_0020);
    chk(csN == 4'hF && !irq && !engTxAvail, "R3 soft reset outputs",
        {27'b0, csN, irq}, {27'b0, 4'hF, 1'b0});
    txQ.delete(); rxQ.delete(); ovfM = 0; doneM = 0; intenM = 0;
    rdReg(I_CTRL, rd); chk(rd == 32'h0004_0020, "R3 ctrl kept", rd, 32'h0004_0020);
    rdReg(I_INTEN, rd); chk(rd == 0, "R3 inten zeroed", rd, 0);
    rdReg(I_CFG, rd); chk(rd == 0, "R3 cfg zeroed", rd, 0);
    rdReg(I_STAT, rd); chk(rd == 32'h3, "R3 status", rd, 32'h3);
    wrReg(I_CTRL, C_ON);
    rxRead("R3 rx emptied");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule